// File: doc/BRIEF.md
# Flash Command Register File with Execution Lockout

This block is the software-facing front end of a flash operation engine. Software fills in a small set of command registers: command type and size, a control word, a target address, per-byte program enables, a bank of data words, a sector protect mask, a verify wait-state setting and a pulse-limit setting. It then writes 1 to an execute register. The block issues a single start pulse to a sequencer, which sees all command fields as plain outputs. From that point every command register ignores writes until the sequencer reports completion.

On completion the block drops the execute bit and the in-progress flag and raises done. It records pass or the individual failure causes reported by the sequencer. It returns the byte-enable register to zero and the data words and protect mask to all ones, so the next command starts from a clean pattern. It also raises a one-cycle done interrupt event. Register access is a single-cycle write strobe with a word index. A combinational read port reflects any register at its word index. Neither port has back-pressure: a write that arrives while a command is in flight is dropped, not stalled.

Top module: `flcmd_regfile`

## Requirements
- R1: A write of 1 in bit 0 to the execute register (word index 0) while no command is in flight is accepted, and `seq_start` is high for exactly the one cycle after the accepting clock edge. `seq_cmd` carries type-register bits 2:0 and `seq_size` carries type-register bits 6:4 (type register at word index 1).
- R2: While a command is in flight, writes to the execute, type, control (index 2), address (index 3), byte-enable (index 4), wait-state (index 5), pulse-limit (index 6), protect (index 8) and data (index 12 upward) registers leave their contents unchanged. Once done is set, those writes take effect again.
- R3: The execute register reads 1 from acceptance until completion, and the block clears it itself when the sequencer reports done.
- R4: At the completing edge, the byte-enable register becomes 0 and every data word and the protect mask become 0xFFFFFFFF.
- R5: The status register (index 7) places done at bit 0, pass at bit 1, in-progress at bit 2, protect failure at bit 4, verify failure at bit 5, illegal address at bit 6, mode failure at bit 7, invalid-data failure at bit 8 and miscellaneous failure at bit 12. `seq_fail` bits 0 to 5 map, in that order, to protect, verify, illegal address, mode, invalid data and miscellaneous. Pass is set at completion only when no fail bit is reported.
- R6: In-progress is set at the accepting edge and cleared at the same edge that sets done.
- R7: Accepting an execute write clears done, pass and every failure flag.
- R8: After reset, the data words and protect mask read 0xFFFFFFFF, the wait-state field (bits 3:0 of index 5) reads 2, the 16-bit byte-enable reads 0, and the execute and status registers read 0.
- R9: `done_irq` is high for exactly one cycle, the cycle after the completing edge, and at no other time.
- R10: Pulse-limit register: bit 0 is the global override, bit 1 is the erase-specific override, and bits 11:4 hold an 8-bit limit. With bit 0 clear, both limits use their hard-wired defaults. With bit 0 set and bit 1 clear, the zero-extended 8-bit limit drives both `prog_max` and `erase_max`. With both bits set, it drives `prog_max` only, and `erase_max` keeps its default.
- R11: A `seq_done` pulse while no command is in flight changes neither the status register nor `done_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Word index of the written register |
| wr_data | input | 32 | Write data |
| rd_idx | input | 6 | Word index of the read register |
| rd_data | output | 32 | Read data, combinational |
| seq_start | output | 1 | One-cycle command start to the sequencer |
| seq_cmd | output | 3 | Command type |
| seq_size | output | 3 | Command size |
| seq_ctrl | output | 32 | Control word |
| seq_addr | output | 32 | Target address |
| seq_byten | output | 16 | Per-byte program enables |
| seq_data | output | 128 | Data words, word 0 in the low bits |
| seq_prot | output | 32 | Sector protect mask |
| seq_wait | output | 4 | Verify wait states |
| prog_max | output | 12 | Effective program pulse limit |
| erase_max | output | 12 | Effective erase pulse limit |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_fail | input | 6 | Failure causes, valid with `seq_done` |
| done_irq | output | 1 | One-cycle done interrupt event |

## Verification
Every register result is due one clock edge after its stimulus. A write lands at the edge that samples `wr_en`. `seq_start`, in-progress and the execute readback appear at that edge's output. Done, pass, the fail flags, the restored registers and `done_irq` all show up together after the edge that samples `seq_done`. The pulse limits follow the pulse-limit register with no added delay. The bench drives inputs on the falling edge and holds each for one rising edge. It reads and compares on the next falling edge, so each check lands in the first cycle its result is due, and the following cycle confirms that single-cycle pulses have dropped.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
  localparam int IDX_W = 6;

  localparam logic [IDX_W-1:0] IDX_EXEC  = 6'd0;
  localparam logic [IDX_W-1:0] IDX_TYPE  = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 6'd2;
  localparam logic [IDX_W-1:0] IDX_ADDR  = 6'd3;
  localparam logic [IDX_W-1:0] IDX_BYTEN = 6'd4;
  localparam logic [IDX_W-1:0] IDX_WAIT  = 6'd5;
  localparam logic [IDX_W-1:0] IDX_PULSE = 6'd6;
  localparam logic [IDX_W-1:0] IDX_STAT  = 6'd7;
  localparam logic [IDX_W-1:0] IDX_PROT  = 6'd8;
  localparam logic [IDX_W-1:0] IDX_DATA0 = 6'd12;

  localparam logic [3:0] WAIT_RST = 4'd2;

  // bit 0 of the packed struct is the protect cause
  typedef struct packed {
    logic misc;
    logic invdata;
    logic mode;
    logic illaddr;
    logic verify;
    logic protect;
  } fail_t;
endpackage

// File: rtl/flcmd_ctrl.sv
module flcmd_ctrl
  import flcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec_wr,
  input  logic        exec_one,
  input  logic        seq_done,
  input  fail_t       seq_fail,
  output logic        busy,
  output logic        finish,
  output logic        start,
  output logic        complete,
  output logic [31:0] status
);
  logic  accept;
  logic  done_q, pass_q;
  fail_t fail_q;

  assign accept = exec_wr && exec_one && !busy;
  assign finish = busy && seq_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      start    <= 1'b0;
      complete <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      fail_q   <= '0;
    end else begin
      start    <= accept;
      complete <= finish;
      if (accept) begin
        busy   <= 1'b1;
        done_q <= 1'b0;
        pass_q <= 1'b0;
        fail_q <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        pass_q <= ~|seq_fail;
        fail_q <= seq_fail;
      end
    end
  end

  always_comb begin
    status     = '0;
    status[0]  = done_q;
    status[1]  = pass_q;
    status[2]  = busy;
    status[4]  = fail_q.protect;
    status[5]  = fail_q.verify;
    status[6]  = fail_q.illaddr;
    status[7]  = fail_q.mode;
    status[8]  = fail_q.invdata;
    status[12] = fail_q.misc;
  end
endmodule

// File: rtl/flcmd_regs.sv
module flcmd_regs
  import flcmd_pkg::*;
#(
  parameter int NUM_DATA = 4,
  parameter int BYTEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ok,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [31:0]            wr_data,
  input  logic                   restore,
  output logic [2:0]             cmd,
  output logic [2:0]             size,
  output logic [31:0]            ctrl,
  output logic [31:0]            addr,
  output logic [BYTEN_W-1:0]     byten,
  output logic [3:0]             wait_st,
  output logic                   pl_glob,
  output logic                   pl_ers,
  output logic [7:0]             pl_val,
  output logic [31:0]            prot,
  output logic [NUM_DATA*32-1:0] data
);
  function automatic logic hit(input logic [IDX_W-1:0] idx);
    return wr_ok && (wr_idx == idx);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd     <= '0;
      size    <= '0;
      ctrl    <= '0;
      addr    <= '0;
      byten   <= '0;
      wait_st <= WAIT_RST;
      pl_glob <= 1'b0;
      pl_ers  <= 1'b0;
      pl_val  <= '0;
      prot    <= '1;
    end else begin
      if (hit(IDX_TYPE)) begin
        cmd  <= wr_data[2:0];
        size <= wr_data[6:4];
      end
      if (hit(IDX_CTRL)) ctrl <= wr_data;
      if (hit(IDX_ADDR)) addr <= wr_data;
      if (hit(IDX_WAIT)) wait_st <= wr_data[3:0];
      if (hit(IDX_PULSE)) begin
        pl_glob <= wr_data[0];
        pl_ers  <= wr_data[1];
        pl_val  <= wr_data[11:4];
      end
      if (restore) begin
        byten <= '0;
        prot  <= '1;
      end else begin
        if (hit(IDX_BYTEN)) byten <= wr_data[BYTEN_W-1:0];
        if (hit(IDX_PROT))  prot  <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(IDX_DATA0) + i);
    always_ff @(posedge clk) begin
      if (!rst_n || restore) data[i*32 +: 32] <= '1;
      else if (hit(MY_IDX))  data[i*32 +: 32] <= wr_data;
    end
  end
endmodule

// File: rtl/flcmd_limits.sv
module flcmd_limits #(
  parameter logic [11:0] DEF_PROG_MAX  = 12'd160,
  parameter logic [11:0] DEF_ERASE_MAX = 12'd2000
) (
  input  logic        pl_glob,
  input  logic        pl_ers,
  input  logic [7:0]  pl_val,
  output logic [11:0] prog_max,
  output logic [11:0] erase_max
);
  logic [11:0] ovr_val;
  assign ovr_val = {4'h0, pl_val};

  always_comb begin
    prog_max  = DEF_PROG_MAX;
    erase_max = DEF_ERASE_MAX;
    if (pl_glob) begin
      prog_max = ovr_val;
      if (!pl_ers) erase_max = ovr_val;
    end
  end
endmodule

// File: rtl/flcmd_regfile.sv
module flcmd_regfile
  import flcmd_pkg::*;
#(
  parameter int          NUM_DATA      = 4,
  parameter int          BYTEN_W       = 16,
  parameter logic [11:0] DEF_PROG_MAX  = 12'd160,
  parameter logic [11:0] DEF_ERASE_MAX = 12'd2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [5:0]             wr_idx,
  input  logic [31:0]            wr_data,
  input  logic [5:0]             rd_idx,
  output logic [31:0]            rd_data,
  output logic                   seq_start,
  output logic [2:0]             seq_cmd,
  output logic [2:0]             seq_size,
  output logic [31:0]            seq_ctrl,
  output logic [31:0]            seq_addr,
  output logic [BYTEN_W-1:0]     seq_byten,
  output logic [NUM_DATA*32-1:0] seq_data,
  output logic [31:0]            seq_prot,
  output logic [3:0]             seq_wait,
  output logic [11:0]            prog_max,
  output logic [11:0]            erase_max,
  input  logic                   seq_done,
  input  logic [5:0]             seq_fail,
  output logic                   done_irq
);
  logic        busy, finish;
  logic [31:0] status;
  logic        pl_glob, pl_ers;
  logic [7:0]  pl_val;

  flcmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .exec_wr(wr_en && (wr_idx == IDX_EXEC)), .exec_one(wr_data[0]),
    .seq_done(seq_done), .seq_fail(fail_t'(seq_fail)),
    .busy(busy), .finish(finish), .start(seq_start),
    .complete(done_irq), .status(status)
  );

  flcmd_regs #(.NUM_DATA(NUM_DATA), .BYTEN_W(BYTEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ok(wr_en && !busy), .wr_idx(wr_idx), .wr_data(wr_data),
    .restore(finish),
    .cmd(seq_cmd), .size(seq_size), .ctrl(seq_ctrl), .addr(seq_addr),
    .byten(seq_byten), .wait_st(seq_wait),
    .pl_glob(pl_glob), .pl_ers(pl_ers), .pl_val(pl_val),
    .prot(seq_prot), .data(seq_data)
  );

  flcmd_limits #(.DEF_PROG_MAX(DEF_PROG_MAX), .DEF_ERASE_MAX(DEF_ERASE_MAX)) u_lim (
    .pl_glob(pl_glob), .pl_ers(pl_ers), .pl_val(pl_val),
    .prog_max(prog_max), .erase_max(erase_max)
  );

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IDX_EXEC:  rd_data = {31'b0, busy};
      IDX_TYPE:  rd_data = {25'b0, seq_size, 1'b0, seq_cmd};
      IDX_CTRL:  rd_data = seq_ctrl;
      IDX_ADDR:  rd_data = seq_addr;
      IDX_BYTEN: rd_data = 32'(seq_byten);
      IDX_WAIT:  rd_data = {28'b0, seq_wait};
      IDX_PULSE: rd_data = {20'b0, pl_val, 2'b0, pl_ers, pl_glob};
      IDX_STAT:  rd_data = status;
      IDX_PROT:  rd_data = seq_prot;
      default: begin
        for (int i = 0; i < NUM_DATA; i++)
          if (rd_idx == IDX_W'(int'(IDX_DATA0) + i)) rd_data = seq_data[i*32 +: 32];
      end
    endcase
  end
endmodule

// File: rtl/flcmd_sva.sv
module flcmd_sva #(
  parameter int NUM_DATA = 4,
  parameter int BYTEN_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   seq_start,
  input logic                   seq_done,
  input logic                   done_irq,
  input logic [2:0]             seq_cmd,
  input logic [31:0]            seq_addr,
  input logic [BYTEN_W-1:0]     seq_byten,
  input logic [NUM_DATA*32-1:0] seq_data,
  input logic [31:0]            seq_prot
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R1
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy); // R6
  AST_LOCK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seq_addr)); // R2
  AST_LOCK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seq_cmd)); // R2
  AST_RESTORE_BYTEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && seq_done |=> seq_byten == '0); // R4
  AST_RESTORE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && seq_done |=> (&seq_data) && (&seq_prot)); // R4
  AST_IRQ_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && seq_done |=> done_irq && !busy); // R9
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R9
  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !seq_start |=> !done_irq); // R11
endmodule

bind flcmd_regfile flcmd_sva #(.NUM_DATA(NUM_DATA), .BYTEN_W(BYTEN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .seq_start(seq_start),
  .seq_done(seq_done), .done_irq(done_irq), .seq_cmd(seq_cmd),
  .seq_addr(seq_addr), .seq_byten(seq_byten), .seq_data(seq_data),
  .seq_prot(seq_prot)
);

// File: tb/tb_flcmd_regfile.sv
module tb_flcmd_regfile;
  localparam int ND = 4;
  localparam logic [5:0] I_EXEC = 0, I_TYPE = 1, I_CTRL = 2, I_ADDR = 3, I_BYTEN = 4,
                         I_WAIT = 5, I_PULSE = 6, I_STAT = 7, I_PROT = 8, I_DATA0 = 12;

  logic clk = 0, rst_n = 0, wr_en = 0, seq_done = 0;
  logic [5:0] wr_idx = 0, rd_idx = 0, seq_fail = 0;
  logic [31:0] wr_data = 0, rd_data, seq_ctrl, seq_addr, seq_prot;
  logic seq_start, done_irq;
  logic [2:0] seq_cmd, seq_size;
  logic [15:0] seq_byten;
  logic [ND*32-1:0] seq_data;
  logic [3:0] seq_wait;
  logic [11:0] prog_max, erase_max;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  flcmd_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .seq_start(seq_start), .seq_cmd(seq_cmd),
    .seq_size(seq_size), .seq_ctrl(seq_ctrl), .seq_addr(seq_addr), .seq_byten(seq_byten),
    .seq_data(seq_data), .seq_prot(seq_prot), .seq_wait(seq_wait), .prog_max(prog_max),
    .erase_max(erase_max), .seq_done(seq_done), .seq_fail(seq_fail), .done_irq(done_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] idx, output logic [31:0] d);
    rd_idx = idx; #1; d = rd_data;
  endtask

  task automatic finish_seq(input logic [5:0] f);
    @(negedge clk); seq_done = 1; seq_fail = f;
    @(negedge clk); seq_done = 0; seq_fail = 0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(I_DATA0, v);     chk("R8 data0", v, 32'hFFFF_FFFF);
    rd(I_DATA0 + 3, v); chk("R8 data3", v, 32'hFFFF_FFFF);
    rd(I_PROT, v);      chk("R8 prot", v, 32'hFFFF_FFFF);
    rd(I_WAIT, v);      chk("R8 wait", v, 32'd2);
    rd(I_BYTEN, v);     chk("R8 byten", v, 32'd0);
    rd(I_EXEC, v);      chk("R8 exec", v, 32'd0);
    rd(I_STAT, v);      chk("R8 status", v, 32'd0);
  endtask

  task automatic t_start;
    logic [31:0] v;
    wr(I_TYPE, 32'h25);
    wr(I_ADDR, 32'h0000_1230);
    wr(I_BYTEN, 32'hFFFF);
    wr(I_DATA0, 32'h1234_5678);
    wr(I_PROT, 32'h0);
    wr(I_EXEC, 32'h1);
    chk("R1 start", {31'b0, seq_start}, 1);
    chk("R1 cmd", {29'b0, seq_cmd}, 5);
    chk("R1 size", {29'b0, seq_size}, 2);
    rd(I_STAT, v); chk("R6 inprog", v, 32'h4);
    rd(I_EXEC, v); chk("R3 exec set", v, 1);
    @(negedge clk);
    chk("R1 start one cycle", {31'b0, seq_start}, 0);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(I_ADDR, 32'hDEAD_BEEF);  rd(I_ADDR, v);  chk("R2 addr locked", v, 32'h0000_1230);
    wr(I_BYTEN, 32'h00F0);      rd(I_BYTEN, v); chk("R2 byten locked", v, 32'hFFFF);
    wr(I_DATA0, 32'h0);         rd(I_DATA0, v); chk("R2 data locked", v, 32'h1234_5678);
    wr(I_TYPE, 32'h71);         rd(I_TYPE, v);  chk("R2 type locked", v, 32'h25);
    wr(I_WAIT, 32'h9);          rd(I_WAIT, v);  chk("R2 wait locked", v, 2);
    wr(I_PROT, 32'h5);          rd(I_PROT, v);  chk("R2 prot locked", v, 0);
    wr(I_EXEC, 32'h1);
    chk("R2 exec no restart", {31'b0, seq_start}, 0);
    rd(I_STAT, v); chk("R2 status still busy", v, 32'h4);
  endtask

  task automatic t_complete_pass;
    logic [31:0] v;
    finish_seq(6'b0);
    chk("R9 irq", {31'b0, done_irq}, 1);
    rd(I_STAT, v);  chk("R5 pass status", v, 32'h3);
    rd(I_EXEC, v);  chk("R3 exec cleared", v, 0);
    rd(I_BYTEN, v); chk("R4 byten zero", v, 0);
    rd(I_DATA0, v); chk("R4 data ones", v, 32'hFFFF_FFFF);
    rd(I_PROT, v);  chk("R4 prot ones", v, 32'hFFFF_FFFF);
    rd(I_ADDR, v);  chk("R4 addr kept", v, 32'h0000_1230);
    @(negedge clk);
    chk("R9 irq one cycle", {31'b0, done_irq}, 0);
    wr(I_ADDR, 32'hCAFE_0000); rd(I_ADDR, v); chk("R2 unlocked", v, 32'hCAFE_0000);
  endtask

  task automatic t_fail(input logic [5:0] f, input logic [31:0] exp);
    logic [31:0] v;
    wr(I_EXEC, 32'h1);
    rd(I_STAT, v); chk("R7 status cleared", v, 32'h4);
    repeat (3) @(negedge clk);
    finish_seq(f);
    rd(I_STAT, v); chk("R5 fail status", v, exp);
    chk("R9 irq on fail", {31'b0, done_irq}, 1);
  endtask

  task automatic t_idle_done;
    logic [31:0] v;
    @(negedge clk);
    rd(I_STAT, v);
    finish_seq(6'b111111);
    chk("R11 no irq idle", {31'b0, done_irq}, 0);
    begin
      logic [31:0] w;
      rd(I_STAT, w); chk("R11 status unchanged", w, v);
    end
  endtask

  task automatic t_limits;
    wr(I_PULSE, 32'h0000_0370);
    chk("R10 default prog", {20'b0, prog_max}, 32'd160);
    chk("R10 default erase", {20'b0, erase_max}, 32'd2000);
    wr(I_PULSE, 32'h0000_0371);
    chk("R10 glob prog", {20'b0, prog_max}, 32'h37);
    chk("R10 glob erase", {20'b0, erase_max}, 32'h37);
    wr(I_PULSE, 32'h0000_0373);
    chk("R10 ers prog", {20'b0, prog_max}, 32'h37);
    chk("R10 ers erase", {20'b0, erase_max}, 32'd2000);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_start();
    t_lock();
    t_complete_pass();
    t_fail(6'b100001, 32'h0000_1011);
    t_fail(6'b011110, 32'h0000_01E1);
    t_idle_done();
    t_limits();
    summary();
    $finish;
  end
endmodule